// File: doc/BRIEF.md
# Dual-Sided Interprocessor Messaging Unit

This block is a mailbox shared by two processors, called side A and side B. Each side has its own 32-bit register port with a write strobe and a read strobe. Each side sees four transmit data registers, four receive data registers, a status word and a control word. A word that one side writes into transmit slot n shows up in receive slot n on the other side. Flags in both status words track whether each slot holds a word that has not been read yet.

The unit also carries four doorbells in each direction. A side rings doorbell n by writing a request bit in its own control word. This raises a pending flag in the other side's status word. The receiver clears that flag by writing a 1 to it.

Each side has one interrupt output. It is high whenever any of its status flags is set while the matching enable bit in its control word is set. Reads have no wait state: `x_rdata` follows `x_addr` in the same cycle. The side effect of a read (clearing a receive-full flag) takes place at the clock edge that ends the read cycle.

Register map, the same on both sides (byte addresses, word aligned): transmit slot n at 4·n, receive slot n at 0x10+4·n, status at 0x20, control at 0x24. An access with address bits [1:0] not zero, or to any other address, selects nothing and reads 0.

Top module: `ipc_mailbox`

## Requirements
- R1: A write to transmit slot n on one side stores the word for receive slot n on the other side. From the next clock on, that side's receive-full flag n reads 1, the writer's transmit-empty flag n reads 0, and a read of receive slot n returns the written word.
- R2: A read of receive slot n clears the reader's receive-full flag n and sets the writer's transmit-empty flag n at the end of the read cycle.
- R3: A write to a transmit slot whose word has not been read replaces the stored word. The flags stay as they are, and no other status bit changes.
- R4: When one side writes transmit slot n in the same cycle that the other side reads receive slot n, the read returns the older word. The full flag stays set afterwards, and the newer word is the one delivered next.
- R5: Status layout for channel n: doorbell-pending at bit 28+(3-n), receive-full at bit 24+(3-n), transmit-empty at bit 20+(3-n). Bit 9 is the busy bit of R11. Every other status bit reads 0.
- R6: After reset both control words read 0 and both interrupts are low. Both status words read 0x00F00000, meaning all transmit slots are empty.
- R7: Control bits 28+(3-n), 24+(3-n) and 20+(3-n) enable the doorbell, receive-full and transmit-empty flags of channel n. A side's interrupt is high exactly when at least one of its enabled flags is set.
- R8: Writing 1 to control bit 16+(3-n) requests doorbell n. The request bit reads 1 for one cycle and then clears by itself. In the same clock step, the other side's doorbell-pending flag n becomes 1.
- R9: Writing 1 to a doorbell-pending status bit clears it. Writing 0 leaves it unchanged. Writes to any other status bit are ignored.
- R10: A doorbell request written while the other side's pending flag n is still set is dropped. The request bit stays 0 and the pending flag stays 1.
- R11: Status bit 9 reads 1 while any doorbell request from this side is still in flight, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from address |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational from address |
| b_irq | output | 1 | Side B interrupt |

## Verification
Two events can fall in the same cycle: one side writing a transmit slot while the other side reads the paired receive slot. The bench forces this by raising side A's write strobe and side B's read strobe at the same falling edge. It then checks that B's read returned the old word, that B's full flag and A's empty flag show a word still waiting, and that B's next read returns the new word. A second overlap comes from a doorbell request that arrives while the far pending flag is still set. That request must leave no trace in the request bit, the busy bit or the pending flag.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 6;

    localparam int GIP_LO   = 28;
    localparam int RF_LO    = 24;
    localparam int TE_LO    = 20;
    localparam int GIR_LO   = 16;
    localparam int BUSY_BIT = 9;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TX,
        SEL_RX,
        SEL_STAT,
        SEL_CTRL
    } sel_e;

    // channel 0 maps to the top bit of its group
    function automatic int flag_pos(input int lo, input int ch);
        return lo + (NCH - 1) - ch;
    endfunction
endpackage

// File: rtl/ipc_lane.sv
module ipc_lane #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] word,
    output logic          full
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] word;
    } lane_t;

    lane_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.word = wdata;
            st_d.full = 1'b1;
        end else if (rd) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;
    assign full = st_q.full;

    AST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n) wr |=> full); // R1
    AST_RD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (rd && !wr) |=> !full); // R2
    AST_LAST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) wr |=> (word == $past(wdata))); // R3
    AST_COLLIDE_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rd && wr) |=> full); // R4
endmodule

// File: rtl/ipc_bell.sv
module ipc_bell (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic pend_clr,
    output logic req,
    output logic pend
);
    typedef struct packed {
        logic req;
        logic pend;
    } bell_t;

    bell_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.req)                   st_d.req = 1'b0;
        else if (req_set && !st_q.pend) st_d.req = 1'b1;
        if (st_q.req)                   st_d.pend = 1'b1;
        else if (pend_clr)              st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req  = st_q.req;
    assign pend = st_q.pend;

    AST_REQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) req |=> (!req && pend)); // R8
    AST_W1C_PEND: assert property (@(posedge clk) disable iff (!rst_n) (pend_clr && !req) |=> !pend); // R9
    AST_REQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (pend && !req && !pend_clr) |=> (!req && pend)); // R10
endmodule

// File: rtl/ipc_side.sv
module ipc_side
    import ipc_pkg::*;
#(
    parameter int N  = ipc_pkg::NCH,
    parameter int DW = ipc_pkg::DW,
    parameter int AW = ipc_pkg::AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic                  irq,
    input  logic [N-1:0][DW-1:0]  rx_word,
    input  logic [N-1:0]          rx_full,
    input  logic [N-1:0]          tx_full,
    input  logic [N-1:0]          bell_pend,
    input  logic [N-1:0]          bell_req,
    output logic [DW-1:0]         tx_word,
    output logic [N-1:0]          tx_wr,
    output logic [N-1:0]          rx_rd,
    output logic [N-1:0]          req_set,
    output logic [N-1:0]          pend_clr
);
    localparam int IW = AW - 2;
    localparam int CW = $clog2(N);
    localparam logic [IW-1:0] RX_IX   = IW'(N);
    localparam logic [IW-1:0] STAT_IX = IW'(2 * N);
    localparam logic [IW-1:0] CTRL_IX = IW'(2 * N + 1);

    typedef struct packed {
        logic [N-1:0] gie;
        logic [N-1:0] rie;
        logic [N-1:0] tie;
    } en_t;

    en_t en_q, en_d;

    sel_e          sel;
    logic [IW-1:0] widx;
    logic [CW-1:0] ch;
    logic [DW-1:0] stat_v, ctrl_v;

    // address decode
    always_comb begin
        widx = addr[AW-1:2];
        ch   = widx[CW-1:0];
        sel  = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (widx < RX_IX)         sel = SEL_TX;
            else if (widx < STAT_IX)  sel = SEL_RX;
            else if (widx == STAT_IX) sel = SEL_STAT;
            else if (widx == CTRL_IX) sel = SEL_CTRL;
        end
    end

    // strobes toward lanes and doorbells, enable register next state
    always_comb begin
        en_d     = en_q;
        tx_wr    = '0;
        rx_rd    = '0;
        req_set  = '0;
        pend_clr = '0;
        if (wr && sel == SEL_TX) tx_wr[ch] = 1'b1;
        if (rd && sel == SEL_RX) rx_rd[ch] = 1'b1;
        for (int n = 0; n < N; n++) begin
            if (wr && sel == SEL_CTRL) begin
                en_d.gie[n] = wdata[flag_pos(GIP_LO, n)];
                en_d.rie[n] = wdata[flag_pos(RF_LO, n)];
                en_d.tie[n] = wdata[flag_pos(TE_LO, n)];
                req_set[n]  = wdata[flag_pos(GIR_LO, n)];
            end
            if (wr && sel == SEL_STAT)
                pend_clr[n] = wdata[flag_pos(GIP_LO, n)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // status and control read images
    always_comb begin
        stat_v = '0;
        ctrl_v = '0;
        for (int n = 0; n < N; n++) begin
            stat_v[flag_pos(GIP_LO, n)] = bell_pend[n];
            stat_v[flag_pos(RF_LO, n)]  = rx_full[n];
            stat_v[flag_pos(TE_LO, n)]  = !tx_full[n];
            ctrl_v[flag_pos(GIP_LO, n)] = en_q.gie[n];
            ctrl_v[flag_pos(RF_LO, n)]  = en_q.rie[n];
            ctrl_v[flag_pos(TE_LO, n)]  = en_q.tie[n];
            ctrl_v[flag_pos(GIR_LO, n)] = bell_req[n];
        end
        stat_v[BUSY_BIT] = |bell_req;
    end

    always_comb begin
        case (sel)
            SEL_RX:   rdata = rx_word[ch];
            SEL_STAT: rdata = stat_v;
            SEL_CTRL: rdata = ctrl_v;
            default:  rdata = '0;
        endcase
    end

    assign irq = |(bell_pend & en_q.gie) | |(rx_full & en_q.rie) | |(~tx_full & en_q.tie);
    assign tx_word = wdata;

    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({tx_wr, rx_rd})); // R1
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (en_q == '0) |-> !irq); // R6
    AST_CTRL_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !(wr && sel == SEL_CTRL) |=> $stable(en_q)); // R7
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
    parameter int N  = ipc_pkg::NCH,
    parameter int DW = ipc_pkg::DW,
    parameter int AW = ipc_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [N-1:0][DW-1:0] ab_word, ba_word;
    logic [N-1:0]         ab_full, ba_full;
    logic [N-1:0]         ab_req, ab_pend, ba_req, ba_pend;
    logic [N-1:0]         a_tx_wr, a_rx_rd, a_req_set, a_pend_clr;
    logic [N-1:0]         b_tx_wr, b_rx_rd, b_req_set, b_pend_clr;
    logic [DW-1:0]        a_tx_word, b_tx_word;

    ipc_side #(.N(N), .DW(DW), .AW(AW)) u_side_a (
        .clk(clk), .rst_n(rst_n), .wr(a_wr), .rd(a_rd), .addr(a_addr),
        .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq),
        .rx_word(ba_word), .rx_full(ba_full), .tx_full(ab_full),
        .bell_pend(ba_pend), .bell_req(ab_req), .tx_word(a_tx_word),
        .tx_wr(a_tx_wr), .rx_rd(a_rx_rd), .req_set(a_req_set), .pend_clr(a_pend_clr)
    );

    ipc_side #(.N(N), .DW(DW), .AW(AW)) u_side_b (
        .clk(clk), .rst_n(rst_n), .wr(b_wr), .rd(b_rd), .addr(b_addr),
        .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq),
        .rx_word(ab_word), .rx_full(ab_full), .tx_full(ba_full),
        .bell_pend(ab_pend), .bell_req(ba_req), .tx_word(b_tx_word),
        .tx_wr(b_tx_wr), .rx_rd(b_rx_rd), .req_set(b_req_set), .pend_clr(b_pend_clr)
    );

    for (genvar n = 0; n < N; n++) begin : g_chan
        ipc_lane #(.DW(DW)) u_lane_ab (
            .clk(clk), .rst_n(rst_n), .wr(a_tx_wr[n]), .rd(b_rx_rd[n]),
            .wdata(a_tx_word), .word(ab_word[n]), .full(ab_full[n])
        );
        ipc_lane #(.DW(DW)) u_lane_ba (
            .clk(clk), .rst_n(rst_n), .wr(b_tx_wr[n]), .rd(a_rx_rd[n]),
            .wdata(b_tx_word), .word(ba_word[n]), .full(ba_full[n])
        );
        ipc_bell u_bell_ab (
            .clk(clk), .rst_n(rst_n), .req_set(a_req_set[n]), .pend_clr(b_pend_clr[n]),
            .req(ab_req[n]), .pend(ab_pend[n])
        );
        ipc_bell u_bell_ba (
            .clk(clk), .rst_n(rst_n), .req_set(b_req_set[n]), .pend_clr(a_pend_clr[n]),
            .req(ba_req[n]), .pend(ba_pend[n])
        );
    end
endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] STAT = 6'h20;
    localparam logic [5:0] CTRL = 6'h24;
    localparam logic [31:0] IDLE = 32'h00F0_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic a_irq, b_irq;
    int nchk = 0;
    int nerr = 0;

    ipc_mailbox u0 (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] bit_at(input int lo, input int ch);
        return 32'h1 << (lo + 3 - ch);
    endfunction

    function automatic logic [5:0] tx_a(input int ch);
        return 6'(4 * ch);
    endfunction

    function automatic logic [5:0] rx_a(input int ch);
        return 6'(16 + 4 * ch);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input bit sd, input logic [5:0] adr, input logic [31:0] d);
        if (!sd) begin a_wr = 1; a_addr = adr; a_wdata = d; end
        else     begin b_wr = 1; b_addr = adr; b_wdata = d; end
        @(posedge clk); @(negedge clk);
        a_wr = 0; b_wr = 0;
    endtask

    task automatic bus_rd(input bit sd, input logic [5:0] adr, output logic [31:0] q);
        if (!sd) begin a_rd = 1; a_addr = adr; end
        else     begin b_rd = 1; b_addr = adr; end
        #1 q = sd ? b_rdata : a_rdata;
        @(posedge clk); @(negedge clk);
        a_rd = 0; b_rd = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(0, CTRL, v); chk("R6 A ctrl after reset", v, 32'h0);
        bus_rd(1, CTRL, v); chk("R6 B ctrl after reset", v, 32'h0);
        bus_rd(0, STAT, v); chk("R6 A status after reset", v, IDLE);
        bus_rd(1, STAT, v); chk("R6 B status after reset", v, IDLE);
        chk("R6 irq low after reset", {30'b0, a_irq, b_irq}, 32'h0);
    endtask

    task automatic t_data(input bit src, input int ch, input logic [31:0] val);
        logic [31:0] v;
        bus_wr(src, tx_a(ch), val);
        bus_rd(!src, STAT, v); chk("R1 R5 receiver full flag", v, IDLE | bit_at(24, ch));
        bus_rd(src, STAT, v);  chk("R1 R5 writer empty flag", v, IDLE & ~bit_at(20, ch));
        bus_rd(!src, rx_a(ch), v); chk("R1 delivered word", v, val);
        bus_rd(!src, STAT, v); chk("R2 receiver flag cleared", v, IDLE);
        bus_rd(src, STAT, v);  chk("R2 writer empty again", v, IDLE);
    endtask

    task automatic t_overwrite();
        logic [31:0] v;
        bus_wr(0, tx_a(1), 32'h1111_1111);
        bus_wr(0, tx_a(1), 32'h2222_2222);
        bus_rd(1, STAT, v); chk("R3 flags after overwrite", v, IDLE | bit_at(24, 1));
        bus_rd(1, rx_a(1), v); chk("R3 newer word kept", v, 32'h2222_2222);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        bus_wr(0, tx_a(0), 32'hAAAA_0001);
        a_wr = 1; a_addr = tx_a(0); a_wdata = 32'hBBBB_0002;
        b_rd = 1; b_addr = rx_a(0);
        #1 v = b_rdata;
        @(posedge clk); @(negedge clk);
        a_wr = 0; b_rd = 0;
        chk("R4 read during write returns old", v, 32'hAAAA_0001);
        bus_rd(1, STAT, v); chk("R4 receiver still full", v, IDLE | bit_at(24, 0));
        bus_rd(0, STAT, v); chk("R4 writer not empty", v, IDLE & ~bit_at(20, 0));
        bus_rd(1, rx_a(0), v); chk("R4 newer word next", v, 32'hBBBB_0002);
        bus_rd(1, STAT, v); chk("R4 drained", v, IDLE);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bus_wr(0, CTRL, bit_at(24, 2));
        chk("R7 enabled but no flag", {31'b0, a_irq}, 32'h0);
        bus_wr(1, tx_a(2), 32'h0000_5A5A);
        chk("R7 receive-full raises irq", {31'b0, a_irq}, 32'h1);
        bus_rd(0, rx_a(2), v);
        chk("R7 read drops irq", {31'b0, a_irq}, 32'h0);
        bus_wr(0, CTRL, 32'h0);
        bus_wr(1, CTRL, bit_at(20, 1));
        chk("R7 empty slot raises irq", {31'b0, b_irq}, 32'h1);
        bus_rd(1, CTRL, v); chk("R7 control readback", v, bit_at(20, 1));
        bus_wr(1, tx_a(1), 32'h0000_0077);
        chk("R7 filled slot drops irq", {31'b0, b_irq}, 32'h0);
        bus_rd(0, rx_a(1), v);
        bus_wr(1, CTRL, 32'h0);
    endtask

    task automatic t_bell();
        logic [31:0] v;
        bus_wr(0, CTRL, bit_at(16, 1));
        bus_rd(0, STAT, v); chk("R11 busy while in flight", v, IDLE | 32'h200);
        bus_rd(0, CTRL, v); chk("R8 request self-clears", v, 32'h0);
        bus_rd(1, STAT, v); chk("R8 far pending set", v, IDLE | bit_at(28, 1));
        bus_wr(1, CTRL, bit_at(28, 1));
        chk("R7 doorbell irq", {31'b0, b_irq}, 32'h1);
        bus_wr(0, CTRL, bit_at(16, 1));
        bus_rd(0, STAT, v); chk("R10 R11 repeat request dropped", v, IDLE);
        bus_rd(1, STAT, v); chk("R10 pending unchanged", v, IDLE | bit_at(28, 1));
        bus_wr(1, STAT, 32'hFFFF_FFFF & ~bit_at(28, 1));
        bus_rd(1, STAT, v); chk("R9 zero write keeps pending", v, IDLE | bit_at(28, 1));
        bus_wr(1, STAT, bit_at(28, 1));
        bus_rd(1, STAT, v); chk("R9 one write clears pending", v, IDLE);
        chk("R9 irq drops after clear", {31'b0, b_irq}, 32'h0);
        bus_wr(1, CTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data(0, 0, 32'hDEAD_BEEF);
        t_data(1, 3, 32'h1234_5678);
        t_data(0, 2, 32'h0F0F_F0F0);
        t_overwrite();
        t_collide();
        t_irq();
        t_bell();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule